// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block receives 8-bit frames from a clocked synchronous serial link. The link's serial clock and data lines are brought into the system clock domain, and data is sampled on each detected rising edge of the serial clock. Each frame is eight data bits with no start or stop bits, least significant bit first. Bits collect in a private shift register. When the eighth bit lands, the byte is copied into a software-visible data register and a full flag is raised.

Software enables reception, reads the data register, and clears the flags with one-cycle clear pulses. If a frame completes while the full flag is still set, the block keeps the old byte, discards the new one and raises an overrun flag. Framing-error and parity-error flags come from outside logic as set pulses. While any error flag is set, reception stops. It stays stopped until software has cleared every error flag and the full flag. A receive interrupt enable gates two level interrupt requests: one for a received byte and one for an error.

Top module: `clksync_rx`

## Requirements
- R1: Serial clock and data pass through a two-stage synchronizer. On each synchronized rising edge the data bit is shifted in, bit 0 first and bit 7 last. After the eighth bit, if the full flag is clear, the byte goes to `rx_data` and `full_flag` is set. Both are visible three system clocks after the serial clock rise reaches the pin.
- R2: When a frame completes with `full_flag` set, `ovr_flag` is set. `rx_data` keeps its old byte and `full_flag` stays set.
- R3: `irq_rx_done` is high exactly when `rx_ie`=1, `full_flag`=1 and no error flag is set.
- R4: `irq_rx_err` is high exactly when `rx_ie`=1 and at least one of `ovr_flag`, `frm_flag` or `par_flag` is set.
- R5: While any error flag is set, serial clock edges are ignored: `rx_data`, `full_flag` and `ovr_flag` do not change. After an error, reception stays blocked until all error flags and `full_flag` are clear.
- R6: Deasserting `rx_en` resets the bit counter, so the bits of a partial frame are discarded. The next frame starts again at bit 0.
- R7: A one-cycle pulse on `clr_full`, `clr_ovr`, `clr_frm` or `clr_par` clears only its own flag on the next clock. `frm_err_in` and `par_err_in` set `frm_flag` and `par_flag`.
- R8: When a set and a clear hit the same flag in the same cycle, the flag ends up set.
- R9: After reset, all flags, `rx_data` and both interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial clock from the link (asynchronous) |
| sdata_in | input | 1 | Serial data from the link (asynchronous) |
| rx_en | input | 1 | Receive enable; low resets the bit counter |
| rx_ie | input | 1 | Receive interrupt enable |
| clr_full | input | 1 | Pulse: clear the full flag |
| clr_ovr | input | 1 | Pulse: clear the overrun flag |
| clr_frm | input | 1 | Pulse: clear the framing-error flag |
| clr_par | input | 1 | Pulse: clear the parity-error flag |
| frm_err_in | input | 1 | Pulse: set the framing-error flag |
| par_err_in | input | 1 | Pulse: set the parity-error flag |
| rx_data | output | 8 | Last accepted byte |
| full_flag | output | 1 | Receive data register holds an unread byte |
| ovr_flag | output | 1 | Overrun error |
| frm_flag | output | 1 | Framing error |
| par_flag | output | 1 | Parity error |
| irq_rx_done | output | 1 | Receive-complete interrupt request |
| irq_rx_err | output | 1 | Receive-error interrupt request |

## Verification
A bit counter that is off by one shows up in the first frame: the byte lands in `rx_data` one serial clock early or late, with every bit shifted, three system clocks after the last rise. A lock-out that is stuck or released too early does not show until the frame after an error. That frame either fails to load or loads while it should be ignored. This is why the bench sends a frame right after each partial clear. A wrong flag priority appears at the next clock edge as a lost flag, or on the interrupt outputs as a wrong level.

// File: rtl/clksync_rx_pkg.sv
package clksync_rx_pkg;

  typedef struct packed {
    logic full;
    logic ovr;
    logic frm;
    logic par;
  } rx_flags_t;

  function automatic logic any_error(input rx_flags_t f);
    return f.ovr | f.frm | f.par;
  endfunction

  function automatic logic done_request(input rx_flags_t f, input logic ie);
    return ie & f.full & ~any_error(f);
  endfunction

  function automatic logic error_request(input rx_flags_t f, input logic ie);
    return ie & any_error(f);
  endfunction

  // set has priority over clear so no event is lost
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

endpackage

// File: rtl/clksync_rx_sync.sv
module clksync_rx_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= '0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/clksync_rx_shift.sv
module clksync_rx_shift #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_s,
  input  logic             sdata_s,
  input  logic             run,
  output logic             shift_en,
  output logic             frame_done,
  output logic [WIDTH-1:0] frame_byte,
  output logic [CW-1:0]    bit_cnt
);

  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic             sclk_q;
  logic [WIDTH-1:0] shreg;

  // new bit enters at the top; after WIDTH shifts bit 0 sits at the bottom
  function automatic logic [WIDTH-1:0] shift_lsb_first(input logic [WIDTH-1:0] cur,
                                                       input logic b);
    return {b, cur[WIDTH-1:1]};
  endfunction

  assign shift_en   = sclk_s & ~sclk_q & run;
  assign frame_done = shift_en & (bit_cnt == LAST);
  assign frame_byte = shift_lsb_first(shreg, sdata_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (!run) begin
        bit_cnt <= '0;
      end else if (shift_en) begin
        shreg   <= frame_byte;
        bit_cnt <= frame_done ? '0 : bit_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/clksync_rx_flags.sv
module clksync_rx_flags
  import clksync_rx_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic [WIDTH-1:0] frame_byte,
  input  logic             clr_full,
  input  logic             clr_ovr,
  input  logic             clr_frm,
  input  logic             clr_par,
  input  logic             frm_set,
  input  logic             par_set,
  output rx_flags_t        flags,
  output logic [WIDTH-1:0] data_q,
  output logic             blocked
);

  logic full_set, ovr_set, hold_q;

  assign full_set = frame_done & ~flags.full;
  assign ovr_set  = frame_done &  flags.full;
  assign blocked  = any_error(flags) | hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      data_q <= '0;
      hold_q <= 1'b0;
    end else begin
      flags.full <= flag_next(flags.full, full_set, clr_full);
      flags.ovr  <= flag_next(flags.ovr,  ovr_set,  clr_ovr);
      flags.frm  <= flag_next(flags.frm,  frm_set,  clr_frm);
      flags.par  <= flag_next(flags.par,  par_set,  clr_par);
      if (full_set) data_q <= frame_byte;
      if (ovr_set | frm_set | par_set)           hold_q <= 1'b1;
      else if (!any_error(flags) && !flags.full) hold_q <= 1'b0;
    end
  end

endmodule

// File: rtl/clksync_rx.sv
module clksync_rx
  import clksync_rx_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW         = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_in,
  input  logic             sdata_in,
  input  logic             rx_en,
  input  logic             rx_ie,
  input  logic             clr_full,
  input  logic             clr_ovr,
  input  logic             clr_frm,
  input  logic             clr_par,
  input  logic             frm_err_in,
  input  logic             par_err_in,
  output logic [WIDTH-1:0] rx_data,
  output logic             full_flag,
  output logic             ovr_flag,
  output logic             frm_flag,
  output logic             par_flag,
  output logic             irq_rx_done,
  output logic             irq_rx_err
);

  logic [1:0]       line_s;
  logic             run, shift_en, frame_done, blocked;
  logic [WIDTH-1:0] frame_byte;
  logic [CW-1:0]    bit_cnt;
  rx_flags_t        flags;

  clksync_rx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({sclk_in, sdata_in}),
    .sync_out (line_s)
  );

  assign run = rx_en & ~blocked;

  clksync_rx_shift #(.WIDTH(WIDTH)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_s     (line_s[1]),
    .sdata_s    (line_s[0]),
    .run        (run),
    .shift_en   (shift_en),
    .frame_done (frame_done),
    .frame_byte (frame_byte),
    .bit_cnt    (bit_cnt)
  );

  clksync_rx_flags #(.WIDTH(WIDTH)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .frame_byte (frame_byte),
    .clr_full   (clr_full),
    .clr_ovr    (clr_ovr),
    .clr_frm    (clr_frm),
    .clr_par    (clr_par),
    .frm_set    (frm_err_in),
    .par_set    (par_err_in),
    .flags      (flags),
    .data_q     (rx_data),
    .blocked    (blocked)
  );

  assign full_flag   = flags.full;
  assign ovr_flag    = flags.ovr;
  assign frm_flag    = flags.frm;
  assign par_flag    = flags.par;
  assign irq_rx_done = done_request(flags, rx_ie);
  assign irq_rx_err  = error_request(flags, rx_ie);

endmodule

// File: rtl/clksync_rx_chk.sv
module clksync_rx_chk #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_en,
  input logic             rx_ie,
  input logic             frm_err_in,
  input logic             par_err_in,
  input logic [WIDTH-1:0] rx_data,
  input logic             full_flag,
  input logic             ovr_flag,
  input logic             frm_flag,
  input logic             par_flag,
  input logic             irq_rx_done,
  input logic             irq_rx_err,
  input logic             frame_done,
  input logic [WIDTH-1:0] frame_byte,
  input logic             shift_en,
  input logic             blocked,
  input logic [CW-1:0]    bit_cnt
);

  // R1
  load_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !full_flag |=> full_flag && rx_data == $past(frame_byte));

  // R2
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && full_flag |=> ovr_flag && full_flag && $stable(rx_data));

  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && !full_flag) |=> $stable(rx_data));

  // R3
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_done |-> rx_ie && full_flag && !ovr_flag && !frm_flag && !par_flag);

  // R4
  err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ie && (ovr_flag || frm_flag || par_flag) |-> irq_rx_err && !irq_rx_done);

  // R5
  blocked_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag || frm_flag || par_flag) |-> blocked && !shift_en);

  // R6
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> bit_cnt == '0);

  // R8
  frm_set_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err_in |=> frm_flag);

  // R8
  par_set_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_in |=> par_flag);

endmodule

bind clksync_rx clksync_rx_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_en       (rx_en),
  .rx_ie       (rx_ie),
  .frm_err_in  (frm_err_in),
  .par_err_in  (par_err_in),
  .rx_data     (rx_data),
  .full_flag   (full_flag),
  .ovr_flag    (ovr_flag),
  .frm_flag    (frm_flag),
  .par_flag    (par_flag),
  .irq_rx_done (irq_rx_done),
  .irq_rx_err  (irq_rx_err),
  .frame_done  (frame_done),
  .frame_byte  (frame_byte),
  .shift_en    (shift_en),
  .blocked     (blocked),
  .bit_cnt     (bit_cnt)
);

// File: tb/clksync_rx_tb.sv
module clksync_rx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk_in = 1'b0, sdata_in = 1'b0, rx_en = 1'b0, rx_ie = 1'b0;
  logic       clr_full = 1'b0, clr_ovr = 1'b0, clr_frm = 1'b0, clr_par = 1'b0;
  logic       frm_err_in = 1'b0, par_err_in = 1'b0;
  logic [7:0] rx_data;
  logic       full_flag, ovr_flag, frm_flag, par_flag, irq_rx_done, irq_rx_err;

  int unsigned n_vec = 0, n_bad = 0;
  bit          finished = 1'b0;

  // bench reference model
  logic [7:0] m_data = 8'h00;
  logic       m_full = 1'b0, m_ovr = 1'b0, m_frm = 1'b0, m_par = 1'b0, m_hold = 1'b0;

  always #10 clk = ~clk;

  clksync_rx u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .rx_en(rx_en), .rx_ie(rx_ie), .clr_full(clr_full), .clr_ovr(clr_ovr),
    .clr_frm(clr_frm), .clr_par(clr_par), .frm_err_in(frm_err_in),
    .par_err_in(par_err_in), .rx_data(rx_data), .full_flag(full_flag),
    .ovr_flag(ovr_flag), .frm_flag(frm_flag), .par_flag(par_flag),
    .irq_rx_done(irq_rx_done), .irq_rx_err(irq_rx_err)
  );

  function automatic logic m_err();
    return m_ovr | m_frm | m_par;
  endfunction

  function automatic logic exp_done_irq();
    return rx_ie & m_full & ~m_err();
  endfunction

  function automatic logic exp_err_irq();
    return rx_ie & m_err();
  endfunction

  function automatic void m_settle();
    if (!m_err() && !m_full) m_hold = 1'b0;
  endfunction

  function automatic void m_frame(input logic [7:0] b);
    if (!rx_en || m_err() || m_hold) return;
    if (!m_full) begin m_data = b; m_full = 1'b1; end
    else begin m_ovr = 1'b1; m_hold = 1'b1; end
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "rx_data",  rx_data, m_data);
    check(req, "full",     {7'd0, full_flag}, {7'd0, m_full});
    check(req, "ovr",      {7'd0, ovr_flag},  {7'd0, m_ovr});
    check(req, "frm",      {7'd0, frm_flag},  {7'd0, m_frm});
    check(req, "par",      {7'd0, par_flag},  {7'd0, m_par});
    check({req, " R3"}, "irq_done", {7'd0, irq_rx_done}, {7'd0, exp_done_irq()});
    check({req, " R4"}, "irq_err",  {7'd0, irq_rx_err},  {7'd0, exp_err_irq()});
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdata_in = b; sclk_in = 1'b0;
    repeat (4) @(negedge clk);
    sclk_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // clear_at_done pulses clr_full in the very cycle the last bit loads
  task automatic send_byte(input logic [7:0] b, input bit clear_at_done);
    for (int i = 0; i < 7; i++) send_bit(b[i]);
    @(negedge clk); sdata_in = b[7]; sclk_in = 1'b0;
    repeat (4) @(negedge clk);
    sclk_in = 1'b1;
    @(negedge clk);
    @(negedge clk); clr_full = clear_at_done;
    @(negedge clk); clr_full = 1'b0;
    sclk_in = 1'b0;
    repeat (4) @(negedge clk);
    m_frame(b);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: clr_full = 1'b1;
      1: clr_ovr = 1'b1;
      2: clr_frm = 1'b1;
      3: clr_par = 1'b1;
      4: frm_err_in = 1'b1;
      default: par_err_in = 1'b1;
    endcase
    @(negedge clk);
    clr_full = 1'b0; clr_ovr = 1'b0; clr_frm = 1'b0; clr_par = 1'b0;
    frm_err_in = 1'b0; par_err_in = 1'b0;
    case (which)
      0: m_full = 1'b0;
      1: m_ovr = 1'b0;
      2: m_frm = 1'b0;
      3: m_par = 1'b0;
      4: begin m_frm = 1'b1; m_hold = 1'b1; end
      default: begin m_par = 1'b1; m_hold = 1'b1; end
    endcase
    @(negedge clk);
    m_settle();
  endtask

  task automatic clear_everything();
    pulse(0); pulse(1); pulse(2); pulse(3);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed_sink;
    seed_sink = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    // R9 reset state
    check_all("R9");
    rst_n = 1'b1;
    rx_en = 1'b1;
    rx_ie = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R9");

    // R1 LSB-first load, R3 done request
    send_byte(8'h81, 1'b0);
    check_all("R1");
    pulse(0);
    check_all("R7");

    // R8 clear of full in its own set cycle loses
    send_byte(8'h3C, 1'b1);
    check_all("R8");

    // R2 overrun keeps the first byte, R4 error request
    send_byte(8'hC5, 1'b0);
    check_all("R2");
    check("R2", "kept byte", rx_data, 8'h3C);

    // R5 still blocked after clearing only the overrun flag
    pulse(1);
    send_byte(8'h5A, 1'b0);
    check_all("R5");
    pulse(0);
    send_byte(8'h96, 1'b0);
    check_all("R5");
    check("R5", "accepted after full clear", rx_data, 8'h96);
    pulse(0);

    // R5 framing error blocks reception, R7 clears it
    pulse(4);
    send_byte(8'hE7, 1'b0);
    check_all("R5");
    pulse(2);
    check_all("R7");
    send_byte(8'h24, 1'b0);
    check_all("R5");
    pulse(0);

    // R8 set and clear of the parity flag together
    @(negedge clk); par_err_in = 1'b1; clr_par = 1'b1;
    @(negedge clk); par_err_in = 1'b0; clr_par = 1'b0;
    m_par = 1'b1; m_hold = 1'b1;
    @(negedge clk);
    check_all("R8");
    pulse(3);

    // R6 partial frame discarded by rx_en low
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    @(negedge clk); rx_en = 1'b0;
    repeat (4) @(negedge clk);
    rx_en = 1'b1;
    send_byte(8'hA5, 1'b0);
    check_all("R6");
    check("R6", "restart at bit 0", rx_data, 8'hA5);

    // R3 R4 enable gating off
    rx_ie = 1'b0;
    @(negedge clk);
    check_all("R3");
    pulse(0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int unsigned act;
      act = $urandom % 8;
      rx_ie = 1'($urandom % 2);
      if (act < 4)       send_byte(8'($urandom), 1'b0);
      else if (act == 4) pulse(0);
      else if (act == 5) pulse(1);
      else if (act == 6) pulse(4 + ($urandom % 2));
      else               clear_everything();
      check_all("R1");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule